// File: doc/BRIEF.md
# Counter Overflow Status Register

This block holds a 64-bit word of sticky flags that record overflow and freeze events from a bank of performance counters. Hardware raises a flag with a one-cycle pulse on the matching bit of the event input. Software has no direct write path to the word. It changes flags only through two command words. A one in the clear command drops the matching flag. A one in the set command raises it. Zeros in either command word leave the matching flags alone.

The layout of the word is fixed:

| Bits | Contents |
|------|----------|
| 0 up to `NUM_GP`-1 | General counter overflow flags |
| 32, 33, 34 | Fixed counter overflow flags 0, 1 and 2 |
| 55 | Trace output interrupt flag |
| 58 | Branch record freeze |
| 59 | Counter freeze |
| 60 | Security status flag |
| 61 | Uncore overflow |
| 62 | Store buffer overflow |
| 63 | Condition changed |

All other positions are reserved and read as zero. General flags at or above `NUM_GP` (up to 8) also read as zero, since those counters are not built.

The two command ports are plain strobe-plus-word inputs. They have no back-pressure: a command is taken on every clock edge where its valid is high. The status output is the register itself, so it shows an update one edge after the event or command that caused it.

Top module: `ovf_status_reg`

## Requirements
- R1: After reset every bit of `status_o` is zero.
- R2: A one on an implemented bit of `evt_i` sets that status bit at the next edge, and the bit stays set while no clear reaches it.
- R3: When `clr_valid_i` is high, each one in `clr_word_i` clears the matching status bit at the next edge. Bits with a zero in the word are unchanged. When `clr_valid_i` is low, the word has no effect.
- R4: When `set_valid_i` is high, each one in `set_word_i` sets the matching implemented status bit at the next edge, except bit 63. When `set_valid_i` is low, the word has no effect.
- R5: If a hardware event and a clear command hit the same bit in the same cycle, the bit reads one afterwards.
- R6: If a set command and a clear command hit the same bit in the same cycle, the bit reads one afterwards.
- R7: Reserved bits (8 to 31, 35 to 54, 56 and 57) read zero whatever the event inputs and both command words do.
- R8: General flags with an index at or above `NUM_GP` read zero whatever the event inputs and both command words do. The default `NUM_GP` is 4.
- R9: Bit 63 (condition changed) is raised only by `evt_i[63]`. A set command leaves it at zero, and a clear command can clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 64 | Hardware event pulses, aligned to the status layout |
| clr_valid_i | input | 1 | Clear command strobe |
| clr_word_i | input | 64 | Clear command word, one means clear |
| set_valid_i | input | 1 | Set command strobe |
| set_word_i | input | 64 | Set command word, one means set |
| status_o | output | 64 | Current status flags |

## Verification
The output is the state itself, so a flag cell that takes a wrong value shows it on `status_o` at the very next edge.

A flag can be lost or appear wrongly when a command is merged with the event pulses. Such a fault stays visible until a later clear removes it.

The arbitration faults only appear when two sources collide on the same bit in one cycle. These are event against clear, set against clear, and a set aimed at bit 63. Each of these collisions is driven on purpose, and the result is read one edge later.

// File: rtl/ovf_status_pkg.sv
package ovf_status_pkg;
  localparam int STAT_W    = 64;
  localparam int GP_MAX    = 8;
  localparam int FX_LSB    = 32;
  localparam int FX_NUM    = 3;
  localparam int TRACE_BIT = 55;
  localparam int MISC_LSB  = 58;
  localparam int COND_BIT  = 63;

  // Positions that hold real flags for a given general counter count.
  function automatic logic [STAT_W-1:0] impl_mask(input int num_gp);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < GP_MAX; i++) if (i < num_gp) m[i] = 1'b1;
    for (int i = 0; i < FX_NUM; i++) m[FX_LSB+i] = 1'b1;
    m[TRACE_BIT] = 1'b1;
    for (int i = MISC_LSB; i <= COND_BIT; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Positions that software may force to one.
  function automatic logic [STAT_W-1:0] settable_mask(input int num_gp);
    logic [STAT_W-1:0] m;
    m = impl_mask(num_gp);
    m[COND_BIT] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/ovf_cmd_decode.sv
module ovf_cmd_decode
  import ovf_status_pkg::*;
#(
  parameter logic [STAT_W-1:0] IMPL = '0,
  parameter logic [STAT_W-1:0] SETM = '0
) (
  input  logic [STAT_W-1:0] evt,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_word,
  input  logic              set_valid,
  input  logic [STAT_W-1:0] set_word,
  output logic [STAT_W-1:0] rise_req,
  output logic [STAT_W-1:0] drop_req
);
  logic [STAT_W-1:0] sw_set;
  logic [STAT_W-1:0] hw_set;

  always_comb begin
    hw_set   = evt & IMPL;
    sw_set   = set_valid ? (set_word & SETM) : '0;
    rise_req = hw_set | sw_set;
    drop_req = clr_valid ? (clr_word & IMPL) : '0;
  end
endmodule

// File: rtl/ovf_flag_cell.sv
module ovf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic drop,
  output logic q
);
  // Raising sources outrank a clear aimed at the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (rise) q <= 1'b1;
    else if (drop) q <= 1'b0;
  end
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
  import ovf_status_pkg::*;
#(
  parameter int NUM_GP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] evt_i,
  input  logic        clr_valid_i,
  input  logic [63:0] clr_word_i,
  input  logic        set_valid_i,
  input  logic [63:0] set_word_i,
  output logic [63:0] status_o
);
  localparam logic [STAT_W-1:0] IMPL = impl_mask(NUM_GP);
  localparam logic [STAT_W-1:0] SETM = settable_mask(NUM_GP);

  logic [STAT_W-1:0] rise_req;
  logic [STAT_W-1:0] drop_req;
  logic [STAT_W-1:0] flags;

  ovf_cmd_decode #(.IMPL(IMPL), .SETM(SETM)) u_dec (
    .evt      (evt_i),
    .clr_valid(clr_valid_i),
    .clr_word (clr_word_i),
    .set_valid(set_valid_i),
    .set_word (set_word_i),
    .rise_req (rise_req),
    .drop_req (drop_req)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    ovf_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .rise (rise_req[b]),
      .drop (drop_req[b]),
      .q    (flags[b])
    );
  end

  assign status_o = flags;

  // Events on implemented bits are visible one edge later.
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // A clear with no competing raise drops the bit.
  assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_i |=> ((status_o & $past(clr_word_i & ~evt_i &
      ~(set_valid_i ? set_word_i & SETM : '0))) == '0));

  // A set on a settable bit raises it, even under a clear (R6).
  assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid_i |=> ((status_o & $past(set_word_i & SETM)) == $past(set_word_i & SETM)));

  // Untouched bits hold; a set on bit 63 counts as untouched (R9).
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_o ^ $past(status_o)) &
      ~$past(evt_i | (clr_valid_i ? clr_word_i : '0) |
             (set_valid_i ? set_word_i & SETM : '0))) == '0));

  // Reserved and unbuilt positions never rise.
  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~IMPL) == '0));
endmodule

// File: tb/ovf_status_reg_test.sv
module ovf_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_i = '0;
  logic        clr_valid_i = 1'b0;
  logic [63:0] clr_word_i = '0;
  logic        set_valid_i = 1'b0;
  logic [63:0] set_word_i = '0;
  logic [63:0] status_o;

  int errors = 0;
  int checks = 0;

  localparam logic [63:0] IMPL4 = 64'hFC80_0007_0000_000F;
  localparam logic [63:0] SET4  = 64'h7C80_0007_0000_000F;
  localparam logic [63:0] ALL   = '1;

  ovf_status_reg #(.NUM_GP(4)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .clr_valid_i(clr_valid_i), .clr_word_i(clr_word_i),
    .set_valid_i(set_valid_i), .set_word_i(set_word_i),
    .status_o(status_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // Drive one cycle of stimulus, then return to idle and sample after the edge.
  task automatic cyc(input logic [63:0] ev, input logic cv, input logic [63:0] cw,
                     input logic sv, input logic [63:0] sw);
    evt_i = ev; clr_valid_i = cv; clr_word_i = cw; set_valid_i = sv; set_word_i = sw;
    @(posedge clk); #1;
    evt_i = '0; clr_valid_i = 1'b0; clr_word_i = '0; set_valid_i = 1'b0; set_word_i = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset value", status_o, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle after reset", status_o, '0);
  endtask

  task automatic t_events;
    cyc(ALL, 1'b0, '0, 1'b0, '0);
    chk("R2 all events", status_o, IMPL4);
    chk("R8 unbuilt general flags", {60'd0, status_o[7:4]}, '0);
    cyc('0, 1'b0, '0, 1'b0, '0);
    chk("R2 flags hold", status_o, IMPL4);
    cyc('0, 1'b1, 64'h0000_0001_0000_0005, 1'b0, '0);
    chk("R3 partial clear", status_o, IMPL4 & ~64'h0000_0001_0000_0005);
    cyc('0, 1'b0, ALL, 1'b0, '0);
    chk("R3 clear without valid", status_o, IMPL4 & ~64'h0000_0001_0000_0005);
    cyc('0, 1'b1, ALL, 1'b0, '0);
    chk("R3 full clear", status_o, '0);
  endtask

  task automatic t_set;
    cyc('0, 1'b0, '0, 1'b0, ALL);
    chk("R4 set without valid", status_o, '0);
    cyc('0, 1'b0, '0, 1'b1, ALL);
    chk("R4 set all", status_o, SET4);
    cyc('0, 1'b1, ALL, 1'b0, '0);
    chk("R3 clear after set", status_o, '0);
  endtask

  task automatic t_evt_vs_clr;
    cyc(64'h8000_0000_0000_0001, 1'b1, ALL, 1'b0, '0);
    chk("R5 event beats clear", status_o, 64'h8000_0000_0000_0001);
    cyc('0, 1'b1, ALL, 1'b0, '0);
    chk("R5 cleared next", status_o, '0);
  endtask

  task automatic t_set_vs_clr;
    cyc(ALL, 1'b0, '0, 1'b0, '0);
    cyc('0, 1'b1, ALL, 1'b1, 64'h0000_0002_0000_0000);
    chk("R6 set beats clear", status_o, 64'h0000_0002_0000_0000);
    cyc('0, 1'b1, ALL, 1'b0, '0);
  endtask

  task automatic t_cond_bit;
    cyc('0, 1'b0, '0, 1'b1, 64'h8000_0000_0000_0000);
    chk("R9 set ignored on bit 63", status_o, '0);
    cyc(64'h8000_0000_0000_0000, 1'b0, '0, 1'b0, '0);
    chk("R9 event raises bit 63", status_o, 64'h8000_0000_0000_0000);
    cyc('0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, '0);
    chk("R9 clear drops bit 63", status_o, '0);
  endtask

  task automatic t_reserved;
    cyc(~IMPL4, 1'b0, '0, 1'b0, '0);
    chk("R7 events on reserved", status_o, '0);
    cyc('0, 1'b0, '0, 1'b1, ~IMPL4);
    chk("R7 set on reserved", status_o, '0);
    cyc(64'h0000_0000_0000_00F0, 1'b0, '0, 1'b1, 64'h0000_0000_0000_00F0);
    chk("R8 unbuilt general flags stay zero", status_o, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_events();
    t_set();
    t_evt_vs_clr();
    t_set_vs_clr();
    t_cond_bit();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule